// File: doc/BRIEF.md
# ATA PIO Cycle Timing Sequencer

This block produces one programmed-I/O bus cycle for an ATA device interface each time a start strobe is accepted. A cycle runs through four timed phases: address setup before the strobe, the active strobe, write-data hold after the strobe, and recovery before the next cycle may begin. The length of each phase is given in clock ticks on four interval inputs. These values are captured when the cycle starts and stay fixed until it ends.

The direction input picks the read strobe or the write strobe. On writes the block also drives the data-bus output enable. On reads it gives a one-clock latch pulse at the end of the strobe, so that surrounding logic can capture the data word. When waiting is enabled, the device ready line, brought in through a two-flop synchronizer, can stretch the strobe phase. A one-clock done pulse marks the end of the recovery phase.

The surrounding controller chooses the interval set for the addressed port, captures read data on the latch pulse, and issues the next start after done.

Top module: `ata_pio_cycle_seq`

## Requirements
- R1: While `rst` is high and on the first clock after it falls with `start` low, `rd_strobe`, `wr_strobe`, `bus_oe`, `latch_pulse` and `cycle_done` are all 0. A reset during a cycle aborts it, and no done pulse follows.
- R2: After a start is accepted on clock edge E, the strobe rises on edge E+max(`t_setup`,1).
- R3: The strobe stays high for max(`t_strobe`,1) clocks when no wait is in effect. `dir_write`=1 selects `wr_strobe`, and `dir_write`=0 selects `rd_strobe`. The two strobes are never high together.
- R4: With `rdy_wait_en`=1 the strobe phase does not end while the synchronized `iordy` is low. If `iordy` rises between edges X and X+1 and the strobe interval has already run out, the strobe falls on edge X+3.
- R5: With `rdy_wait_en`=0, a low `iordy` has no effect on strobe width.
- R6: On a read cycle `latch_pulse` is high for exactly the one clock after the strobe falls. On a write cycle it stays 0.
- R7: On a write cycle `bus_oe` rises on the accepting edge and falls max(`t_hold`,1) clocks after the strobe falls. On a read cycle `bus_oe` stays 0.
- R8: `cycle_done` is a single-clock pulse that rises max(`t_recov`,1) clocks after the hold phase ends. There is one pulse per cycle.
- R9: A `start` that arrives while a cycle is in progress is ignored. The running cycle's timing is unchanged, and no second cycle follows.
- R10: The interval, direction and wait-enable inputs are sampled only on the accepting edge. Changing them later in the cycle does not alter it.
- R11: An interval value of 0 behaves as one clock for every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start one bus cycle (accepted when idle) |
| dir_write | input | 1 | 1 = write to device, 0 = read from device |
| rdy_wait_en | input | 1 | 1 = let the ready line stretch the strobe |
| iordy | input | 1 | Device ready line, asynchronous |
| t_setup | input | TW | Setup interval in clocks |
| t_strobe | input | TW | Strobe width in clocks |
| t_hold | input | TW | Write hold interval in clocks |
| t_recov | input | TW | Recovery interval in clocks |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| bus_oe | output | 1 | Data-bus output enable (writes only) |
| latch_pulse | output | 1 | One-clock read-data capture pulse |
| cycle_done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The assertions assume that `start` is a clean synchronous level and that `iordy` either stays steady or changes only between clock edges. Any metastability is left to the synchronizer and is not modelled. The bench drives every input on the falling clock edge, and it changes `iordy` only while the strobe phase is in progress or well before a cycle starts. It also keeps intervals small enough that the hold and recovery checks finish within the run, and it changes the interval inputs in the middle of a cycle only to show that they are ignored.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } pio_phase_e;
endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ata_pio_interval.sv
module ata_pio_interval #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  p_count_moves_r11: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/ata_pio_phase_fsm.sv
module ata_pio_phase_fsm
  import ata_pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       we_in,
  input  logic       we_q,
  input  logic       wait_en_q,
  input  logic       rdy_s,
  input  logic       expired,
  output pio_phase_e phase,
  output pio_phase_e nxt_phase,
  output logic       load,
  output logic       accept,
  output logic       rd_strobe,
  output logic       wr_strobe,
  output logic       bus_oe,
  output logic       latch_pulse,
  output logic       cycle_done
);
  logic advance;

  assign accept  = (phase == PH_IDLE) && start;
  assign advance = expired && ((phase != PH_STROBE) || !wait_en_q || rdy_s);

  always_comb begin
    nxt_phase = phase;
    load      = 1'b0;
    unique case (phase)
      PH_IDLE:   if (start)   begin nxt_phase = PH_SETUP;  load = 1'b1; end
      PH_SETUP:  if (advance) begin nxt_phase = PH_STROBE; load = 1'b1; end
      PH_STROBE: if (advance) begin nxt_phase = PH_HOLD;   load = 1'b1; end
      PH_HOLD:   if (advance) begin nxt_phase = PH_RECOV;  load = 1'b1; end
      PH_RECOV:  if (advance) begin nxt_phase = PH_IDLE; end
      default:   nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      rd_strobe   <= 1'b0;
      wr_strobe   <= 1'b0;
      bus_oe      <= 1'b0;
      latch_pulse <= 1'b0;
      cycle_done  <= 1'b0;
    end else begin
      phase       <= nxt_phase;
      rd_strobe   <= (nxt_phase == PH_STROBE) && !we_q;
      wr_strobe   <= (nxt_phase == PH_STROBE) && we_q;
      latch_pulse <= (phase == PH_STROBE) && advance && !we_q;
      cycle_done  <= (phase == PH_RECOV) && advance;
      if (accept)
        bus_oe <= we_in;
      else if ((phase == PH_HOLD) && advance)
        bus_oe <= 1'b0;
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe));
  p_wr_dir_r3: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> we_q);
  p_wait_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && wait_en_q && !rdy_s) |=> (rd_strobe || wr_strobe));
  p_latch_single_r6: assert property (@(posedge clk) disable iff (rst)
    latch_pulse |=> !latch_pulse);
  p_latch_read_r6: assert property (@(posedge clk) disable iff (rst)
    latch_pulse |-> !we_q);
  p_oe_not_read_r7: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> !bus_oe);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    cycle_done |=> !cycle_done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> (phase == PH_IDLE) && !bus_oe);
endmodule

// File: rtl/ata_pio_cycle_seq.sv
module ata_pio_cycle_seq
  import ata_pio_pkg::*;
#(
  parameter int TW          = 8,
  parameter int DEF_SETUP   = 6,
  parameter int DEF_STROBE  = 28,
  parameter int DEF_HOLD    = 2,
  parameter int DEF_RECOV   = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_write,
  input  logic          rdy_wait_en,
  input  logic          iordy,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_strobe,
  input  logic [TW-1:0] t_hold,
  input  logic [TW-1:0] t_recov,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic          bus_oe,
  output logic          latch_pulse,
  output logic          cycle_done
);
  localparam logic [TW-1:0] RST_SETUP  = TW'(DEF_SETUP);
  localparam logic [TW-1:0] RST_STROBE = TW'(DEF_STROBE);
  localparam logic [TW-1:0] RST_HOLD   = TW'(DEF_HOLD);
  localparam logic [TW-1:0] RST_RECOV  = TW'(DEF_RECOV);

  logic [TW-1:0] setup_q, strobe_q, hold_q, recov_q;
  logic          we_q, wait_en_q;
  logic          rdy_s, expired, load, accept;
  logic [TW-1:0] len_sel;
  pio_phase_e    phase, nxt_phase;

  // Interval shadow: captured on the accepting edge only.
  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q   <= RST_SETUP;
      strobe_q  <= RST_STROBE;
      hold_q    <= RST_HOLD;
      recov_q   <= RST_RECOV;
      we_q      <= 1'b0;
      wait_en_q <= 1'b0;
    end else if (accept) begin
      setup_q   <= t_setup;
      strobe_q  <= t_strobe;
      hold_q    <= t_hold;
      recov_q   <= t_recov;
      we_q      <= dir_write;
      wait_en_q <= rdy_wait_en;
    end
  end

  // Length for the phase being entered; setup comes straight from the inputs.
  always_comb begin
    unique case (nxt_phase)
      PH_SETUP:  len_sel = t_setup;
      PH_STROBE: len_sel = strobe_q;
      PH_HOLD:   len_sel = hold_q;
      PH_RECOV:  len_sel = recov_q;
      default:   len_sel = '0;
    endcase
  end

  ata_pio_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk (clk),
    .rst (rst),
    .d   (iordy),
    .q   (rdy_s)
  );

  ata_pio_interval #(.TW(TW)) u_interval (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .len     (len_sel),
    .expired (expired)
  );

  ata_pio_phase_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .we_in       (dir_write),
    .we_q        (we_q),
    .wait_en_q   (wait_en_q),
    .rdy_s       (rdy_s),
    .expired     (expired),
    .phase       (phase),
    .nxt_phase   (nxt_phase),
    .load        (load),
    .accept      (accept),
    .rd_strobe   (rd_strobe),
    .wr_strobe   (wr_strobe),
    .bus_oe      (bus_oe),
    .latch_pulse (latch_pulse),
    .cycle_done  (cycle_done)
  );

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && start) |=> $stable(we_q) && $stable(strobe_q));
  p_shadow_held_r10: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> $stable(setup_q) && $stable(hold_q) && $stable(recov_q));
endmodule

// File: tb/ata_pio_cycle_seq_bench.sv
`timescale 1ns/1ps
module ata_pio_cycle_seq_bench;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, dir_write = 1'b0, rdy_wait_en = 1'b0, iordy = 1'b1;
  logic [TW-1:0] t_setup = '0, t_strobe = '0, t_hold = '0, t_recov = '0;
  logic rd_strobe, wr_strobe, bus_oe, latch_pulse, cycle_done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ata_pio_cycle_seq #(.TW(TW)) u_ata_pio_cycle_seq (
    .clk(clk), .rst(rst), .start(start), .dir_write(dir_write),
    .rdy_wait_en(rdy_wait_en), .iordy(iordy),
    .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold), .t_recov(t_recov),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .bus_oe(bus_oe),
    .latch_pulse(latch_pulse), .cycle_done(cycle_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic idle_outputs(input string req);
    chk({req, " outputs idle"},
        int'({rd_strobe, wr_strobe, bus_oe, latch_pulse, cycle_done}), 0);
  endtask

  // One full cycle. Index n counts falling edges after the accepting edge (n=0 first).
  task automatic run_cycle(input string tag, input bit we, input bit wen, input bit rdy_lvl,
                           input int t1, input int t2, input int t4, input int te,
                           input int stretch_k, input bit mid_go);
    int a, b, c, d, bw, lim;
    int f_str, n_rd, n_wr, n_oe, l_oe, f_lat, n_lat, f_done, n_done, both;
    a = atleast1(t1); b = atleast1(t2); c = atleast1(t4); d = atleast1(te);
    bw = (stretch_k > 0 && (stretch_k + 3) > b) ? stretch_k + 3 : b;
    lim = a + bw + c + d + 4;
    f_str = -1; n_rd = 0; n_wr = 0; n_oe = 0; l_oe = -1;
    f_lat = -1; n_lat = 0; f_done = -1; n_done = 0; both = 0;
    @(negedge clk);
    dir_write = we; rdy_wait_en = wen; iordy = rdy_lvl;
    t_setup = TW'(t1); t_strobe = TW'(t2); t_hold = TW'(t4); t_recov = TW'(te);
    start = 1'b1;
    @(negedge clk);
    for (int n = 0; n <= lim; n++) begin
      if (rd_strobe || wr_strobe) begin
        if (f_str < 0) f_str = n;
      end
      if (rd_strobe) n_rd++;
      if (wr_strobe) n_wr++;
      if (rd_strobe && wr_strobe) both++;
      if (bus_oe) begin n_oe++; l_oe = n; end
      if (latch_pulse) begin n_lat++; if (f_lat < 0) f_lat = n; end
      if (cycle_done) begin n_done++; if (f_done < 0) f_done = n; end
      // drive after sampling
      if (n == 0) begin
        start = 1'b0;
        // R10: later changes must not matter
        t_setup = 8'd1; t_strobe = 8'd1; t_hold = 8'd1; t_recov = 8'd1;
        dir_write = ~we; rdy_wait_en = ~wen;
      end
      if (mid_go && n == a + 1) start = 1'b1;
      if (mid_go && n == a + 2) start = 1'b0;
      if (stretch_k > 0 && n == a + stretch_k) iordy = 1'b1;
      @(negedge clk);
    end
    chk({tag, " R2 strobe rise"}, f_str, a);
    chk({tag, " R3 strobe excl"}, both, 0);
    chk({tag, " R3 read strobe width"}, n_rd, we ? 0 : bw);
    chk({tag, " R3 write strobe width"}, n_wr, we ? bw : 0);
    chk({tag, " R6 latch count"}, n_lat, we ? 0 : 1);
    if (!we) chk({tag, " R6 latch position"}, f_lat, a + bw);
    chk({tag, " R7 oe width"}, n_oe, we ? a + bw + c : 0);
    if (we) chk({tag, " R7 oe last"}, l_oe, a + bw + c - 1);
    chk({tag, " R8 done position"}, f_done, a + bw + c + d);
    chk({tag, " R8 done count"}, n_done, 1);
    iordy = 1'b1;
  endtask

  task automatic t_reset_state;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    idle_outputs("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    idle_outputs("R1 after reset");
  endtask

  task automatic t_reset_abort;
    int n_done;
    n_done = 0;
    @(negedge clk);
    dir_write = 1'b1; rdy_wait_en = 1'b0;
    t_setup = 8'd2; t_strobe = 8'd6; t_hold = 8'd2; t_recov = 8'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 abort precondition strobe", int'(wr_strobe), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle_outputs("R1 abort");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cycle_done || wr_strobe) n_done++;
    end
    chk("R1 no activity after abort", n_done, 0);
  endtask

  task automatic t_write_default; run_cycle("write mode0", 1, 0, 1, 6, 28, 2, 23, 0, 0); endtask
  task automatic t_read_basic;    run_cycle("read basic", 0, 0, 1, 3, 5, 2, 4, 0, 0); endtask
  task automatic t_zero_read;     run_cycle("R11 zero read", 0, 0, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic t_zero_write;    run_cycle("R11 zero write", 1, 0, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic t_stretch;       run_cycle("R4 stretch read", 0, 1, 0, 2, 4, 1, 2, 6, 0); endtask
  task automatic t_stretch_wr;    run_cycle("R4 stretch write", 1, 1, 0, 1, 3, 3, 1, 8, 0); endtask
  task automatic t_ready_high;    run_cycle("R4 ready high", 0, 1, 1, 2, 4, 1, 2, 0, 0); endtask
  task automatic t_wait_off;      run_cycle("R5 wait off", 0, 0, 0, 2, 4, 1, 2, 0, 0); endtask
  task automatic t_busy_go;       run_cycle("R9 busy start", 1, 0, 1, 2, 5, 3, 4, 0, 1); endtask

  initial begin
    t_reset_state();
    t_write_default();
    t_read_basic();
    t_zero_read();
    t_zero_write();
    t_stretch();
    t_stretch_wr();
    t_ready_high();
    t_wait_off();
    t_busy_go();
    t_reset_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule